// File: doc/BRIEF.md
# HDLC Frame Address Filter

This block sits behind an HDLC receiver's deframer and decides whether each incoming frame is meant for this station. It looks only at the opening one or two address bytes of a frame and compares them against two programmable mask bytes. It latches an accept or reject decision, holds it until the next frame begins, and uses it to gate the write strobe into a downstream receive buffer. Flag hunting, zero-bit removal, CRC checking and the buffer itself are handled elsewhere.

Each mask byte carries its own enable in bit 0. The first-byte compare can cover six or seven address bits. An address field whose seven address bits are all ones is a broadcast ("all-call") and is accepted whatever the mask contents are, provided the needed enables are set. When filtering is switched off, every frame passes and every received byte may be stored.

The controller has five states. `AF_IDLE` is the state after reset and waits for a start-of-frame. `AF_WAIT_A1` waits for the first address byte. `AF_WAIT_A2` waits for the second address byte. `AF_PASS` holds an accept and `AF_DROP` holds a reject. The transitions are as follows:
- start-of-frame moves from any state to `AF_WAIT_A1`.
- In `AF_WAIT_A1`, a byte with extension bit 1 moves to `AF_PASS` or `AF_DROP`, and a byte with extension bit 0 moves to `AF_WAIT_A2`.
- In `AF_WAIT_A2`, the next byte moves to `AF_PASS` or `AF_DROP`.
- End-of-frame in either wait state moves to `AF_DROP`.
- `AF_PASS` and `AF_DROP` stay where they are until the next start-of-frame.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset, with filtering enabled, `accept` is 0 and `store_en` is 0. Bytes that arrive before any start-of-frame do not change this.
- R2: With `seven_bit_mode` = 0 and `cfg_first[0]` = 1, the first address byte matches when its bits 7..2 equal `cfg_first[7:2]`. Bit 1 of the byte and `cfg_first[1]` are not compared.
- R3: With `seven_bit_mode` = 1 and `cfg_first[0]` = 1, the first byte matches only when its bits 7..1 equal `cfg_first[7:1]`.
- R4: When `cfg_first[0]` = 0, the first byte always matches.
- R5: When `cfg_second[0]` = 1, the second byte matches only when its bits 7..1 equal `cfg_second[7:1]`. When `cfg_second[0]` = 0, the second byte always matches. A two-byte address is accepted when both bytes match.
- R6: Bit 0 of an address byte is the extension bit. A first byte with bit 0 = 1 is the whole address. A first byte with bit 0 = 0 means a second byte follows. The decision is always taken on the second byte, whatever its bit 0 is.
- R7: A one-byte address whose bits 7..1 are all ones is accepted when `cfg_first[0]` = 1, even if the mask differs.
- R8: A two-byte address whose second byte has bits 7..1 all ones is accepted, whatever the first byte is, when both `cfg_first[0]` and `cfg_second[0]` are 1. If `cfg_second[0]` = 0, the normal first-byte compare applies instead.
- R9: `accept` reflects the decision from the clock edge that takes the last address byte. It holds through end-of-frame and clears on the edge that takes the next start-of-frame.
- R10: A frame that ends before its address is complete is rejected.
- R11: With `filter_en` = 0, `accept` is 1 and `store_en` equals `byte_vld` at all times.
- R12: With filtering enabled, `store_en` equals `byte_vld` only while an accept is held. It is 0 for address bytes and for bytes of rejected frames.
- R13: A start-of-frame restarts address collection. A byte presented in the same cycle as start-of-frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filter_en | input | 1 | Global address-filter enable |
| seven_bit_mode | input | 1 | 1: compare seven first-byte bits; 0: compare six |
| cfg_first | input | 8 | First-byte mask in bits 7..1, enable in bit 0 |
| cfg_second | input | 8 | Second-byte mask in bits 7..1, enable in bit 0 |
| frame_start | input | 1 | One-cycle start-of-frame marker |
| frame_end | input | 1 | One-cycle end-of-frame marker |
| byte_vld | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| accept | output | 1 | Frame accepted (held decision) |
| store_en | output | 1 | Write strobe toward the receive buffer |

## Verification
The assertions assume that `frame_start` and `frame_end` are single-cycle pulses. They also assume that the mask and mode inputs are steady while a frame's address is being collected, because the first-byte result is registered and combined later. The stimulus follows these assumptions. It changes configuration only between frames, pulses each marker for exactly one cycle, and presents bytes on separate cycles. The one exception is a deliberate collision of a byte with start-of-frame, which exercises the restart rule.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;
    typedef enum logic [2:0] {
        AF_IDLE,
        AF_WAIT_A1,
        AF_WAIT_A2,
        AF_PASS,
        AF_DROP
    } af_state_t;
endpackage

// File: rtl/hdlc_af_match.sv
// Compares the address field (byte bits above the extension bit) with one mask byte.
module hdlc_af_match #(
    parameter int DATA_W = 8,
    localparam int FIELD_W = DATA_W - 1
) (
    input  logic [FIELD_W-1:0] addr_field,
    input  logic [DATA_W-1:0]  mask_cfg,
    input  logic               wide_mode,
    output logic               hit,
    output logic               all_ones,
    output logic               lane_en
);
    logic full_eq;
    logic short_eq;

    always_comb begin
        full_eq  = (addr_field == mask_cfg[DATA_W-1:1]);
        short_eq = (addr_field[FIELD_W-1:1] == mask_cfg[DATA_W-1:2]);
        lane_en  = mask_cfg[0];
        all_ones = &addr_field;
        hit      = !lane_en || (wide_mode ? full_eq : short_eq);
    end
endmodule

// File: rtl/hdlc_af_fsm.sv
module hdlc_af_fsm
    import hdlc_af_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic filter_en,
    input  logic frame_start,
    input  logic frame_end,
    input  logic byte_vld,
    input  logic ext_last,
    input  logic hit1,
    input  logic ones1,
    input  logic en1,
    input  logic hit2,
    input  logic ones2,
    input  logic en2,
    output logic accept,
    output logic store_en
);
    af_state_t state, state_nxt;
    logic      hit1_q;
    logic      dec_single;
    logic      dec_double;

    always_comb begin
        dec_single = (ones1 && en1) || hit1;
        dec_double = (ones2 && en1 && en2) || (hit1_q && hit2);
    end

    // next-state
    always_comb begin
        state_nxt = state;
        if (frame_start) begin
            state_nxt = AF_WAIT_A1;
        end else begin
            unique case (state)
                AF_IDLE:    state_nxt = AF_IDLE;
                AF_WAIT_A1: begin
                    if (frame_end)
                        state_nxt = AF_DROP;
                    else if (byte_vld)
                        state_nxt = ext_last ? (dec_single ? AF_PASS : AF_DROP)
                                             : AF_WAIT_A2;
                end
                AF_WAIT_A2: begin
                    if (frame_end)
                        state_nxt = AF_DROP;
                    else if (byte_vld)
                        state_nxt = dec_double ? AF_PASS : AF_DROP;
                end
                AF_PASS:    state_nxt = AF_PASS;
                AF_DROP:    state_nxt = AF_DROP;
                default:    state_nxt = AF_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= AF_IDLE;
            hit1_q <= 1'b0;
        end else begin
            state <= state_nxt;
            if (state == AF_WAIT_A1 && byte_vld && !frame_start)
                hit1_q <= hit1;
        end
    end

    // outputs
    always_comb begin
        accept   = !filter_en || (state == AF_PASS);
        store_en = byte_vld && accept;
    end

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == AF_IDLE && !frame_start) |=> state == AF_IDLE);

    assert_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == AF_WAIT_A1 && byte_vld && !ext_last && !frame_start && !frame_end)
        |=> state == AF_WAIT_A2);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == AF_PASS || state == AF_DROP) && !frame_start)
        |=> state == $past(state));

    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == AF_WAIT_A1 || state == AF_WAIT_A2) && frame_end && !frame_start)
        |=> state == AF_DROP);

    assert_restart_R13: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> state == AF_WAIT_A1);
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter #(
    parameter int DATA_W = 8,
    localparam int FIELD_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              filter_en,
    input  logic              seven_bit_mode,
    input  logic [DATA_W-1:0] cfg_first,
    input  logic [DATA_W-1:0] cfg_second,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    output logic              accept,
    output logic              store_en
);
    logic hit1, ones1, en1;
    logic hit2, ones2, en2;
    logic [FIELD_W-1:0] field;

    assign field = byte_data[DATA_W-1:1];

    hdlc_af_match #(.DATA_W(DATA_W)) u_match_first (
        .addr_field (field),
        .mask_cfg   (cfg_first),
        .wide_mode  (seven_bit_mode),
        .hit        (hit1),
        .all_ones   (ones1),
        .lane_en    (en1)
    );

    hdlc_af_match #(.DATA_W(DATA_W)) u_match_second (
        .addr_field (field),
        .mask_cfg   (cfg_second),
        .wide_mode  (1'b1),
        .hit        (hit2),
        .all_ones   (ones2),
        .lane_en    (en2)
    );

    hdlc_af_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .filter_en   (filter_en),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .byte_vld    (byte_vld),
        .ext_last    (byte_data[0]),
        .hit1        (hit1),
        .ones1       (ones1),
        .en1         (en1),
        .hit2        (hit2),
        .ones2       (ones2),
        .en2         (en2),
        .accept      (accept),
        .store_en    (store_en)
    );
endmodule

// File: tb/hdlc_addr_filter_test.sv
module hdlc_addr_filter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       filter_en = 1'b1;
    logic       seven_bit_mode = 1'b0;
    logic [7:0] cfg_first = 8'h00;
    logic [7:0] cfg_second = 8'h00;
    logic       frame_start = 1'b0;
    logic       frame_end = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       accept;
    logic       store_en;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit exp_q[$];
    string tag_q[$];
    event decided;

    always #2.5 clk = ~clk;

    hdlc_addr_filter uut (
        .clk(clk), .rst_n(rst_n), .filter_en(filter_en), .seven_bit_mode(seven_bit_mode),
        .cfg_first(cfg_first), .cfg_second(cfg_second), .frame_start(frame_start),
        .frame_end(frame_end), .byte_vld(byte_vld), .byte_data(byte_data),
        .accept(accept), .store_en(store_en)
    );

    task automatic check(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // all tasks start and end at a negedge
    task automatic start_pulse();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic end_pulse();
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b, input bit exp_store, input string tag);
        byte_data = b;
        byte_vld  = 1'b1;
        #1;
        check(store_en, exp_store, tag);
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    // driver: push expectation, drive the frame address, trigger monitor
    task automatic frame(input logic [7:0] b1, input logic [7:0] b2, input bit two,
                         input bit exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        start_pulse();
        put_byte(b1, 1'b0, {tag, " R12 addr byte not stored"});
        if (two) put_byte(b2, 1'b0, {tag, " R12 addr byte not stored"});
        ->decided;
        #2;
        put_byte(8'h5A, exp, {tag, " R12 payload store"});
        end_pulse();
    endtask

    // monitor: compare held decision against queued expectation
    initial begin
        forever begin
            @(decided);
            #1;
            check(accept, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(accept, 1'b0, "R1 reset accept");
        check(store_en, 1'b0, "R1 reset store_en");
        put_byte(8'hFF, 1'b0, "R1 stray byte store");
        check(accept, 1'b0, "R1 stray byte accept");

        // six-bit first compare, mask 101010, bit1=0, en
        cfg_first = 8'b1010_1001; cfg_second = 8'h00;
        frame(8'b1010_1011, 8'h00, 0, 1'b1, "R2 bit1 ignored");
        frame(8'b1000_1001, 8'h00, 0, 1'b0, "R2 mismatch");
        seven_bit_mode = 1'b1;
        frame(8'b1010_1011, 8'h00, 0, 1'b0, "R3 bit1 compared");
        frame(8'b1010_1001, 8'h00, 0, 1'b1, "R3 exact match");
        cfg_first = 8'b1010_1000;
        frame(8'h35, 8'h00, 0, 1'b1, "R4 first disabled");
        // two-byte addresses
        seven_bit_mode = 1'b0;
        cfg_first = 8'hA9; cfg_second = 8'h25;
        frame(8'hA8, 8'h25, 1, 1'b1, "R5 second match");
        frame(8'hA8, 8'h27, 1, 1'b0, "R5 second mismatch");
        frame(8'h00, 8'h25, 1, 1'b0, "R5 first mismatch");
        frame(8'hA8, 8'h24, 1, 1'b1, "R6 second ext bit ignored");
        cfg_second = 8'h24;
        frame(8'hA8, 8'h27, 1, 1'b1, "R5 second disabled");
        // broadcast
        cfg_second = 8'h25;
        frame(8'hFF, 8'h00, 0, 1'b1, "R7 single all-call");
        frame(8'h00, 8'hFF, 1, 1'b1, "R8 two-byte all-call");
        frame(8'h00, 8'hFE, 1, 1'b1, "R8 all-call ext0");
        cfg_second = 8'h24;
        frame(8'h00, 8'hFF, 1, 1'b0, "R8 needs second enable");
        cfg_second = 8'h25;

        // R9 hold through end, clear on start
        frame(8'hFF, 8'h00, 0, 1'b1, "R9 setup");
        check(accept, 1'b1, "R9 held after end");
        @(negedge clk);
        check(accept, 1'b1, "R9 held idle cycle");
        start_pulse();
        check(accept, 1'b0, "R9 cleared by start");

        // R10 abort before address completes
        put_byte(8'hA8, 1'b0, "R10 addr byte");
        end_pulse();
        check(accept, 1'b0, "R10 aborted rejected");
        put_byte(8'h25, 1'b0, "R10 late byte not stored");
        check(accept, 1'b0, "R10 stays rejected");

        // R13 byte in same cycle as start ignored
        byte_data = 8'hFF; byte_vld = 1'b1; frame_start = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0; frame_start = 1'b0;
        put_byte(8'h01, 1'b0, "R13 addr byte");
        check(accept, 1'b0, "R13 colliding all-call ignored");

        // R11 filter disabled
        filter_en = 1'b0;
        #1;
        check(accept, 1'b1, "R11 accept when disabled");
        check(store_en, 1'b0, "R11 store idle");
        start_pulse();
        put_byte(8'h01, 1'b1, "R11 addr byte stored");
        check(accept, 1'b1, "R11 accept after mismatch");
        filter_en = 1'b1;
        #1;
        check(accept, 1'b0, "R12 filter back on rejects");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule